// File: doc/BRIEF.md
# Two-Cluster Fuzzy Membership Pipeline

This unit computes, one pixel at a time, how strongly an 8-bit grey pixel belongs to the first of two fuzzy clusters. A fuzzy exponent of 2 is assumed. Each valid cycle the caller presents a pixel and the two cluster centers in use for the current frame. Three cycles later the unit returns an 8-bit membership value, where 255 means "fully cluster 1" and 0 means "fully cluster 2". It accepts a new pixel every cycle, so it can sit directly in a video stream. Accumulating statistics and recomputing the centers are left to neighbouring logic.

Membership uses the squared distances from the pixel to both centers. The ratio of inverse squares is rewritten as `(256 * D2) / (D1 + D2)`, so no reciprocal is needed, and the result is clamped to 8 bits. For the first frame, before any centers exist, a start-up input replaces the supplied centers with black for cluster 1 and white for cluster 2.

Top module: `membership_update`

## Requirements
- R1: While reset is asserted, and right after it, `outValid` is 0 and `membership` is 0.
- R2: A pixel presented with `inValid` high yields exactly one `outValid` pulse, 3 clock cycles after the edge that sampled it. Cycles without `inValid` yield no output pulse.
- R3: With D1 = (pixel - c1)^2 and D2 = (pixel - c2)^2, where the difference is taken as larger minus smaller, `membership` equals floor(256 * D2 / (D1 + D2)) whenever that value is below 256.
- R4: When the pixel equals the effective center 1 and differs from the effective center 2, `membership` saturates to 255.
- R5: When the pixel equals the effective center 2 and differs from the effective center 1, `membership` is 0.
- R6: When both squared distances are zero, `membership` is 128.
- R7: While `initMode` is 1, the effective centers are 0x00 for cluster 1 and 0xFF for cluster 2, and the `center1` and `center2` inputs have no effect.
- R8: While no result is being delivered, `membership` keeps its last value and `outValid` stays 0, whatever the inputs do.
- R9: Pixels presented on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Pixel and centers are valid this cycle |
| pixel | input | 8 | Unsigned grey level |
| center1 | input | 8 | Current center of cluster 1 |
| center2 | input | 8 | Current center of cluster 2 |
| initMode | input | 1 | Start-up mode: use fixed centers 0x00 and 0xFF |
| outValid | output | 1 | Membership result valid |
| membership | output | 8 | Membership of the pixel in cluster 1, 0..255 |

## Verification
A fixed table of hand-computed cases is streamed back to back. It includes pixels between the centers, pixels outside both centers, centers in reversed order, and near-equal distances where truncation decides the last bit. These cases separate a correct long division from one that rounds, swaps operands or mis-handles the absolute difference. Pixels equal to one center, to the other, or to both at once check the saturation, zero and tie rules apart. Start-up-mode cases with arbitrary supplied centers show whether the fixed centers really replace them. A long random stream, with frequent pixel-equals-center hits, is then compared against an integer model. Idle gaps check that the output holds its value and that no spurious valid pulse appears.

// File: rtl/membership_pkg.sv
package membership_pkg;
  localparam int unsigned STAGES = 3;

  typedef struct packed {
    logic ldDist;
    logic ldSquare;
    logic ldResult;
  } stageStrobe_t;
endpackage

// File: rtl/membership_ctrl.sv
module membership_ctrl
  import membership_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobe.ldDist   = inValid;
    strobe.ldSquare = validPipe[0];
    strobe.ldResult = validPipe[1];
  end

  assign outValid = validPipe[STAGES-1];
endmodule

// File: rtl/membership_datapath.sv
module membership_datapath
  import membership_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobe_t     strobe,
  input  logic [PIX_W-1:0] pixel,
  input  logic [PIX_W-1:0] center1,
  input  logic [PIX_W-1:0] center2,
  input  logic             initMode,
  output logic [PIX_W-1:0] membership
);
  localparam int unsigned SQ_W   = 2 * PIX_W;
  localparam int unsigned SUM_W  = SQ_W + 1;
  localparam int unsigned DIVD_W = SQ_W + PIX_W;
  localparam int unsigned REM_W  = SUM_W + 1;
  localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};
  localparam logic [PIX_W-1:0] PIX_HALF = PIX_W'(1) << (PIX_W - 1);

  // stage 1: effective centers and absolute distances
  logic [PIX_W-1:0] effC1, effC2, dist1D, dist2D;
  logic [PIX_W-1:0] dist1Q, dist2Q;

  always_comb begin
    effC1  = initMode ? '0 : center1;
    effC2  = initMode ? PIX_MAX : center2;
    dist1D = (pixel > effC1) ? pixel - effC1 : effC1 - pixel;
    dist2D = (pixel > effC2) ? pixel - effC2 : effC2 - pixel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dist1Q <= '0;
      dist2Q <= '0;
    end else if (strobe.ldDist) begin
      dist1Q <= dist1D;
      dist2Q <= dist2D;
    end
  end

  // stage 2: squares
  logic [SQ_W-1:0] sq1Q, sq2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sq1Q <= '0;
      sq2Q <= '0;
    end else if (strobe.ldSquare) begin
      sq1Q <= SQ_W'(dist1Q) * SQ_W'(dist1Q);
      sq2Q <= SQ_W'(dist2Q) * SQ_W'(dist2Q);
    end
  end

  // stage 3: restoring division of (sq2 << PIX_W) by (sq1 + sq2)
  logic [SUM_W-1:0]  divisor;
  logic [DIVD_W-1:0] dividend, quotient;
  logic [REM_W-1:0]  remainder;
  logic [PIX_W-1:0]  ratio;

  always_comb begin
    divisor   = SUM_W'(sq1Q) + SUM_W'(sq2Q);
    dividend  = {sq2Q, {PIX_W{1'b0}}};
    remainder = '0;
    quotient  = '0;
    for (int i = DIVD_W - 1; i >= 0; i--) begin
      remainder = {remainder[REM_W-2:0], dividend[i]};
      if (remainder >= REM_W'(divisor)) begin
        remainder   = remainder - REM_W'(divisor);
        quotient[i] = 1'b1;
      end
    end
    if (divisor == '0)
      ratio = PIX_HALF;
    else if (quotient > DIVD_W'(PIX_MAX))
      ratio = PIX_MAX;
    else
      ratio = quotient[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 membership <= '0;
    else if (strobe.ldResult)  membership <= ratio;
  end
endmodule

// File: rtl/membership_update.sv
module membership_update
  import membership_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PIX_W-1:0] pixel,
  input  logic [PIX_W-1:0] center1,
  input  logic [PIX_W-1:0] center2,
  input  logic             initMode,
  output logic             outValid,
  output logic [PIX_W-1:0] membership
);
  stageStrobe_t strobe;

  membership_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  membership_datapath #(.PIX_W(PIX_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pixel      (pixel),
    .center1    (center1),
    .center2    (center2),
    .initMode   (initMode),
    .membership (membership)
  );
endmodule

// File: rtl/membership_update_checker.sv
module membership_update_checker #(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [PIX_W-1:0] pixel,
  input logic [PIX_W-1:0] center1,
  input logic [PIX_W-1:0] center2,
  input logic             initMode,
  input logic             outValid,
  input logic [PIX_W-1:0] membership
);
  localparam logic [PIX_W-1:0] TOP = {PIX_W{1'b1}};
  localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

  logic [1:0] sinceReset;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceReset <= '0;
    else if (!(&sinceReset)) sinceReset <= sinceReset + 2'd1;
  end
  assign warm = &sinceReset;

  logic [PIX_W-1:0] effC1, effC2;
  assign effC1 = initMode ? '0 : center1;
  assign effC2 = initMode ? TOP : center2;

  always_comb begin
    if (!rstN) assert_reset_quiet_R1: assert (!outValid && membership == '0);
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (outValid == $past(inValid, 3)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !outValid) |-> $stable(membership));

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 3) && $past(pixel == effC1, 3) && $past(pixel != effC2, 3))
      |-> (membership == TOP));

  assert_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 3) && $past(pixel == effC2, 3) && $past(pixel != effC1, 3))
      |-> (membership == '0));

  assert_tie_R6: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 3) && $past(pixel == effC1, 3) && $past(pixel == effC2, 3))
      |-> (membership == MID));

  assert_init_black_R7: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 3) && $past(initMode, 3) && $past(pixel == '0, 3))
      |-> (membership == TOP));
endmodule

bind membership_update membership_update_checker #(.PIX_W(PIX_W)) i_checker (.*);

// File: tb/test_membership_update.sv
module test_membership_update;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] pixel = '0;
  logic [7:0] center1 = '0;
  logic [7:0] center2 = '0;
  logic       initMode = 1'b0;
  logic       outValid;
  logic [7:0] membership;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  bit doneRun = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  membership_update i_membership_update (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pixel(pixel),
    .center1(center1), .center2(center2), .initMode(initMode),
    .outValid(outValid), .membership(membership)
  );

  // {initMode, pixel, center1, center2, expected}
  localparam int NVEC = 12;
  localparam logic [32:0] VECS [NVEC] = '{
    {1'b0, 8'd100, 8'd50,  8'd200, 8'd204},  // R3 between centers
    {1'b0, 8'd10,  8'd0,   8'd255, 8'd255},  // R3 quotient clamps
    {1'b0, 8'd128, 8'd100, 8'd156, 8'd128},  // R3 equal distances
    {1'b0, 8'd25,  8'd20,  8'd40,  8'd230},  // R3 truncation
    {1'b0, 8'd0,   8'd255, 8'd1,   8'd0},    // R3 tiny ratio
    {1'b0, 8'd60,  8'd60,  8'd200, 8'd255},  // R4 on center 1
    {1'b0, 8'd200, 8'd60,  8'd200, 8'd0},    // R5 on center 2
    {1'b0, 8'd77,  8'd77,  8'd77,  8'd128},  // R6 both zero
    {1'b1, 8'd0,   8'd123, 8'd45,  8'd255},  // R7 black at start-up
    {1'b1, 8'd255, 8'd9,   8'd255, 8'd0},    // R7 white at start-up
    {1'b1, 8'd128, 8'd128, 8'd128, 8'd126},  // R7 mid grey, centers ignored
    {1'b0, 8'd30,  8'd40,  8'd20,  8'd128}   // R3 reversed centers
  };

  logic [7:0] expQ [$];
  int         issueQ [$];
  string      tagQ [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int refModel(input bit im, input int p, input int c1, input int c2);
    int e1, e2, d1, d2, q;
    e1 = im ? 0 : c1;
    e2 = im ? 255 : c2;
    d1 = (p - e1) * (p - e1);
    d2 = (p - e2) * (p - e2);
    if (d1 + d2 == 0) return 128;
    q = (256 * d2) / (d1 + d2);
    return (q > 255) ? 255 : q;
  endfunction

  task automatic push(input bit im, input logic [7:0] p, input logic [7:0] c1,
                      input logic [7:0] c2, input logic [7:0] e, input string tag);
    @(negedge clk);
    inValid = 1'b1; initMode = im; pixel = p; center1 = c1; center2 = c2;
    expQ.push_back(e);
    issueQ.push_back(cycle + 1);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      pixel = pixel + 8'd37; center1 = center1 ^ 8'h5A; initMode = ~initMode;
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected outValid", 1, 0);
      end else begin
        logic [7:0] e;
        int iss;
        string t;
        e = expQ.pop_front();
        iss = issueQ.pop_front();
        t = tagQ.pop_front();
        check(membership == e, t, membership, e);
        check(cycle - iss == 2, "R2 latency", cycle - iss + 1, 3);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    check(membership == 8'd0, "R1 membership in reset", membership, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && membership == 8'd0, "R1 after reset", membership, 0);

    // table, streamed back to back (R9)
    for (int v = 0; v < NVEC; v++)
      push(VECS[v][32], VECS[v][31:24], VECS[v][23:16], VECS[v][15:8], VECS[v][7:0],
           $sformatf("R3 vector %0d", v));
    idle(6);
    check(expQ.size() == 0, "R9 all results delivered", expQ.size(), 0);

    // R8: hold during idle with changing inputs
    held = membership;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      inValid = 1'b0; pixel = 8'(k * 51); center2 = 8'(k * 13);
      check(!outValid && membership == held, "R8 hold while idle", membership, held);
    end

    // random stream with frequent center hits and gaps
    for (int n = 0; n < 400; n++) begin
      logic [7:0] p, a, b;
      bit im;
      int sel;
      p = 8'($urandom_range(0, 255));
      a = 8'($urandom_range(0, 255));
      b = 8'($urandom_range(0, 255));
      im = ($urandom_range(0, 7) == 0);
      sel = $urandom_range(0, 5);
      if (sel == 0) p = a;
      else if (sel == 1) p = b;
      else if (sel == 2) begin a = b; p = b; end
      push(im, p, a, b, 8'(refModel(im, p, a, b)), "R3 random");
      if ($urandom_range(0, 9) == 0) idle(1);
    end
    idle(6);
    check(expQ.size() == 0, "R2 one result per pixel", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule